// File: doc/BRIEF.md
# Half-Bridge Overcurrent Limiter

This block sits beside one half-bridge of a class-D power stage and decides what happens when that bridge's overcurrent comparator fires. It takes the PWM level the modulator asks for, a frame-start strobe that marks the start of each PWM period, and a one-cycle overcurrent pulse. It returns the PWM level that is actually applied to the bridge, a Hi-Z indication, and an overload-shutdown request for the chip's fault manager.

Two protection modes are chosen by a 4-bit configuration code.

- **Limiting mode:** an overcurrent event inverts the bridge output and holds that inverted level until the next frame starts. An up/down overload counter tracks how many frames saw an overcurrent. When overcurrent persists for too many frames, the bridge is shut down.
- **Latched mode:** the first overcurrent event shuts the bridge down at once.

In both modes a shutdown lasts until a rising edge of the reset pin. The code also supplies a 2-bit threshold index to the analog comparator reference. `CNT_MAX` sets the counter limit; at a 384 kHz frame rate, about 650 frames gives roughly 1.7 ms of sustained limiting before shutdown.

Top module: `ocl_limiter`

## Requirements
- R1: Configuration code bits 3:2 select the mode: 2'b01 is limiting and 2'b10 is latched. For these codes `thr_sel` equals code bits 1:0, where index 0 is the highest current and index 3 the lowest.
- R2: A mode field of 2'b00 or 2'b11 is invalid. It gives `thr_sel` = 3 (the minimum threshold) whatever bits 1:0 hold, and the block behaves in limiting mode.
- R3: In limiting mode, an `oc_pulse` in a cycle where no forced level is active and the bridge is not Hi-Z has this effect from the next cycle on: `pwm_out` is the inverse of the level it had in the pulse cycle, and `limit_active` is 1.
- R4: While a forced level is active, `pwm_out` holds it regardless of `pwm_want` and of further `oc_pulse`. From the cycle after the next `frame_start`, `pwm_out` follows `pwm_want` again and `limit_active` is 0.
- R5: At each `frame_start`, the overload counter closes the ending frame. It goes up by one if that frame held an overcurrent event and down by one, stopping at zero, if it did not. An event in the `frame_start` cycle itself belongs to the new frame.
- R6: When a closing frame brings the counter to `CNT_MAX`, then from the next cycle `bridge_hiz` and `ovld_shutdown` are 1 and `pwm_out` and `limit_active` are 0.
- R7: In latched mode, the first `oc_pulse` sets `bridge_hiz` and `ovld_shutdown` from the next cycle, with no flip of the output beforehand.
- R8: A shutdown stays in place through `oc_pulse`, `frame_start`, configuration changes and a low `reset_pin_n`. In the cycle after a rising edge of `reset_pin_n`, the shutdown and the counter are cleared and `pwm_out` follows `pwm_want`.
- R9: After `rst_n`, `bridge_hiz`, `ovld_shutdown` and `limit_active` are 0, `pwm_out` equals `pwm_want`, and the counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| reset_pin_n | input | 1 | Synchronised device reset pin; its rising edge clears a shutdown |
| cfg_code | input | 4 | Mode field (bits 3:2) and threshold index (bits 1:0) |
| frame_start | input | 1 | One-cycle strobe at the start of each PWM frame |
| oc_pulse | input | 1 | One-cycle overcurrent comparator event |
| pwm_want | input | 1 | PWM level requested by the modulator |
| pwm_out | output | 1 | PWM level applied to the half-bridge |
| bridge_hiz | output | 1 | Half-bridge is held in the high-impedance state |
| ovld_shutdown | output | 1 | Overload shutdown request to the fault manager |
| limit_active | output | 1 | A cycle-by-cycle forced level is in effect |
| thr_sel | output | 2 | Threshold index for the comparator reference |

## Verification
Single overcurrent pulses are applied with the requested level both high and low. This shows a true inversion of the applied level rather than a fixed forced value. Repeated pulses and requested-level changes inside a forced frame show that the level is held. Runs of clean frames at a zero count separate a saturating counter from a wrapping one. Mixed runs of overcurrent and clean frames that end one frame short of the limit, and then exactly at it, show that the count really goes down as well as up. A pulse coinciding with the frame strobe checks which frame it is charged to. Shutdowns are hit with pulses, frame strobes, mode changes and a low reset pin to show that only the rising edge clears them. The latched, limiting and invalid codes are compared by whether a pulse flips the output or shuts the bridge down.

// File: rtl/ocl_pkg.sv
package ocl_pkg;

    localparam int CODE_W = 4;
    localparam int THR_W  = 2;

    localparam logic [1:0] MODE_FLD_LIMIT = 2'b01;
    localparam logic [1:0] MODE_FLD_LATCH = 2'b10;
    localparam logic [THR_W-1:0] THR_MIN  = '1;

    typedef enum logic {
        OCM_LIMIT = 1'b0,
        OCM_LATCH = 1'b1
    } ocm_e;

    typedef struct packed {
        ocm_e             mode;
        logic [THR_W-1:0] thr;
    } cfg_dec_t;

    typedef struct packed {
        logic forced;
        logic lvl;
    } flip_st_t;

    function automatic cfg_dec_t decode_cfg(input logic [CODE_W-1:0] code);
        cfg_dec_t r;
        unique case (code[CODE_W-1 -: 2])
            MODE_FLD_LIMIT: begin r.mode = OCM_LIMIT; r.thr = code[THR_W-1:0]; end
            MODE_FLD_LATCH: begin r.mode = OCM_LATCH; r.thr = code[THR_W-1:0]; end
            default:        begin r.mode = OCM_LIMIT; r.thr = THR_MIN;          end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ocl_cfg_decode.sv
module ocl_cfg_decode
    import ocl_pkg::*;
(
    input  logic [CODE_W-1:0] cfg_code,
    output ocm_e              mode,
    output logic [THR_W-1:0]  thr_sel
);
    cfg_dec_t dec;

    always_comb begin
        dec     = decode_cfg(cfg_code);
        mode    = dec.mode;
        thr_sel = dec.thr;
    end

endmodule

// File: rtl/ocl_reset_edge.sv
module ocl_reset_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic rise
);
    logic pin_d, pin_q;

    always_comb begin
        pin_d = pin_n;
        rise  = pin_n & ~pin_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b1;
        else        pin_q <= pin_d;
    end

endmodule

// File: rtl/ocl_flip_ctrl.sv
module ocl_flip_ctrl
    import ocl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic oc_act,
    input  logic clear,
    input  logic pwm_want,
    output logic pwm_cur,
    output logic forced
);
    flip_st_t st_d, st_q;

    always_comb begin
        pwm_cur = st_q.forced ? st_q.lvl : pwm_want;
        forced  = st_q.forced;
        st_d    = st_q;
        if (clear) begin
            st_d = '0;
        end else if (frame_start) begin
            // a new frame releases the forced level; an event here opens a new one
            st_d.forced = oc_act;
            st_d.lvl    = oc_act ? ~pwm_cur : 1'b0;
        end else if (oc_act && !st_q.forced) begin
            st_d.forced = 1'b1;
            st_d.lvl    = ~pwm_cur;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_FLIP_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.forced && oc_act && !clear) |=> (st_q.forced && st_q.lvl != $past(pwm_cur))); // R3

    AST_FLIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.forced && !frame_start && !clear) |=> (st_q.forced && $stable(st_q.lvl))); // R4

endmodule

// File: rtl/ocl_ovld_counter.sv
module ocl_ovld_counter #(
    parameter int CNT_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic oc_act,
    input  logic clear,
    output logic ovf
);
    localparam int CNT_W = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(CNT_MAX);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             seen;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        ovf  = 1'b0;
        if (clear) begin
            st_d = '0;
        end else if (frame_start) begin
            if (st_q.seen) begin
                if (st_q.cnt < TOP) st_d.cnt = st_q.cnt + 1'b1;
                ovf = (st_q.cnt == TOP - 1'b1);
            end else if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
            st_d.seen = oc_act;
        end else begin
            st_d.seen = st_q.seen | oc_act;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= TOP); // R5

    AST_CNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !clear && st_q.seen && st_q.cnt < TOP)
        |=> (st_q.cnt == $past(st_q.cnt) + 1'b1)); // R5

    AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !clear && !st_q.seen && st_q.cnt == '0) |=> (st_q.cnt == '0)); // R5

endmodule

// File: rtl/ocl_limiter.sv
module ocl_limiter
    import ocl_pkg::*;
#(
    parameter int CNT_MAX = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_pin_n,
    input  logic [CODE_W-1:0] cfg_code,
    input  logic              frame_start,
    input  logic              oc_pulse,
    input  logic              pwm_want,
    output logic              pwm_out,
    output logic              bridge_hiz,
    output logic              ovld_shutdown,
    output logic              limit_active,
    output logic [THR_W-1:0]  thr_sel
);
    ocm_e mode;
    logic rise, ovf, pwm_cur, forced;
    logic oc_lim, oc_latch, trip_set, flip_clear;
    logic trip_d, trip_q;

    ocl_cfg_decode u_dec (
        .cfg_code (cfg_code),
        .mode     (mode),
        .thr_sel  (thr_sel)
    );

    ocl_reset_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (reset_pin_n),
        .rise  (rise)
    );

    always_comb begin
        oc_lim   = oc_pulse && mode == OCM_LIMIT && !trip_q && !rise;
        oc_latch = oc_pulse && mode == OCM_LATCH && !trip_q && !rise;
    end

    ocl_ovld_counter #(.CNT_MAX(CNT_MAX)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .oc_act      (oc_lim),
        .clear       (rise),
        .ovf         (ovf)
    );

    always_comb begin
        trip_set   = ovf | oc_latch;
        flip_clear = rise | trip_set | trip_q;
        if (rise) trip_d = 1'b0;
        else      trip_d = trip_q | trip_set;
    end

    ocl_flip_ctrl u_flip (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .oc_act      (oc_lim),
        .clear       (flip_clear),
        .pwm_want    (pwm_want),
        .pwm_cur     (pwm_cur),
        .forced      (forced)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trip_q <= 1'b0;
        else        trip_q <= trip_d;
    end

    always_comb begin
        bridge_hiz    = trip_q;
        ovld_shutdown = trip_q;
        pwm_out       = trip_q ? 1'b0 : pwm_cur;
        limit_active  = forced & ~trip_q;
    end

    AST_LATCH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_pulse && mode == OCM_LATCH && !rise) |=> bridge_hiz); // R7

    AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (bridge_hiz && !rise) |=> bridge_hiz); // R8

    AST_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !bridge_hiz); // R8

    AST_HIZ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (bridge_hiz && !pwm_out && !limit_active)); // R6

endmodule

// File: tb/sim_ocl_limiter.sv
module sim_ocl_limiter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reset_pin_n = 1'b1;
    logic [3:0] cfg_code = 4'b0100;
    logic       frame_start = 1'b0;
    logic       oc_pulse = 1'b0;
    logic       pwm_want = 1'b0;
    logic       pwm_out, bridge_hiz, ovld_shutdown, limit_active;
    logic [1:0] thr_sel;

    always #2 clk = ~clk;

    ocl_limiter #(.CNT_MAX(8)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .reset_pin_n   (reset_pin_n),
        .cfg_code      (cfg_code),
        .frame_start   (frame_start),
        .oc_pulse      (oc_pulse),
        .pwm_want      (pwm_want),
        .pwm_out       (pwm_out),
        .bridge_hiz    (bridge_hiz),
        .ovld_shutdown (ovld_shutdown),
        .limit_active  (limit_active),
        .thr_sel       (thr_sel)
    );

    typedef struct {
        int    pwm;
        int    hiz;
        int    lim;
        string req;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // driver: inputs change at the falling edge, expectation is for after the next rising edge
    task automatic drv(input logic fs, input logic oc, input logic want, input logic pin,
                       input int ep, input int eh, input int el, input string req);
        exp_t e;
        @(negedge clk);
        frame_start = fs;
        oc_pulse    = oc;
        pwm_want    = want;
        reset_pin_n = pin;
        e.pwm = ep; e.hiz = eh; e.lim = el; e.req = req;
        q.push_back(e);
    endtask

    // monitor: pops one expectation per rising edge and compares it
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            if (e.pwm >= 0) check(e.req, "pwm_out", int'(pwm_out), e.pwm);
            if (e.hiz >= 0) begin
                check(e.req, "bridge_hiz", int'(bridge_hiz), e.hiz);
                check(e.req, "ovld_shutdown", int'(ovld_shutdown), e.hiz);
            end
            if (e.lim >= 0) check(e.req, "limit_active", int'(limit_active), e.lim);
        end
    end

    task automatic finish_up;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic oc_frame(input int last_hiz, input string req);
        drv(0, 1, 1, 1, 0, 0, 1, req);
        drv(1, 0, 1, 1, last_hiz ? 0 : 1, last_hiz, 0, req);
    endtask

    task automatic set_cfg(input logic [3:0] c, input int exp_thr, input string req);
        @(negedge clk);
        cfg_code = c;
        #1;
        check(req, "thr_sel", int'(thr_sel), exp_thr);
    endtask

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        check("R9", "bridge_hiz", int'(bridge_hiz), 0);
        check("R9", "limit_active", int'(limit_active), 0);
        check("R9", "pwm_out", int'(pwm_out), int'(pwm_want));
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "thr_sel", int'(thr_sel), 0);

        // R3 / R4: flip from high, hold through pulses and request changes
        drv(1, 0, 0, 1, 0, 0, 0, "R4");
        drv(0, 0, 1, 1, 1, 0, 0, "R4");
        drv(0, 1, 1, 1, 0, 0, 1, "R3");
        drv(0, 0, 0, 1, 0, 0, 1, "R4");
        drv(0, 1, 1, 1, 0, 0, 1, "R4");
        drv(0, 0, 1, 1, 0, 0, 1, "R4");
        drv(1, 0, 1, 1, 1, 0, 0, "R4");
        // flip from low
        drv(0, 0, 0, 1, 0, 0, 0, "R3");
        drv(0, 1, 0, 1, 1, 0, 1, "R3");
        drv(0, 0, 0, 1, 1, 0, 1, "R4");
        drv(1, 0, 0, 1, 0, 0, 0, "R4");
        // count is 2; four clean frames leave it saturated at 0
        for (int i = 0; i < 4; i++) drv(1, 0, 0, 1, 0, 0, 0, "R5");
        // seven event frames reach 7 without shutdown
        for (int i = 0; i < 7; i++) oc_frame(0, "R5");
        // eighth reaches the limit
        oc_frame(1, "R6");

        // R8: shutdown holds through pulses, frames, mode change, low reset pin
        drv(0, 1, 1, 1, 0, 1, 0, "R8");
        drv(1, 0, 1, 1, 0, 1, 0, "R8");
        set_cfg(4'b1000, 0, "R1");
        drv(0, 1, 0, 1, 0, 1, 0, "R8");
        set_cfg(4'b0100, 0, "R1");
        drv(0, 0, 1, 0, 0, 1, 0, "R8");
        drv(0, 0, 1, 1, 1, 0, 0, "R8");

        // R5: event in the frame-start cycle belongs to the new frame
        drv(1, 1, 1, 1, 0, 0, 1, "R5");
        drv(1, 0, 1, 1, 1, 0, 0, "R5");
        for (int i = 0; i < 6; i++) oc_frame(0, "R5");
        drv(1, 0, 0, 1, 0, 0, 0, "R5");
        drv(1, 0, 0, 1, 0, 0, 0, "R5");
        oc_frame(0, "R5");
        oc_frame(0, "R5");
        oc_frame(1, "R5");
        drv(0, 0, 1, 0, 0, 1, 0, "R8");
        drv(0, 0, 1, 1, 1, 0, 0, "R8");

        // R7: latched mode
        set_cfg(4'b1001, 1, "R1");
        drv(0, 1, 1, 1, 0, 1, 0, "R7");
        drv(1, 0, 1, 1, 0, 1, 0, "R7");
        drv(0, 0, 1, 0, 0, 1, 0, "R8");
        drv(0, 0, 1, 1, 1, 0, 0, "R8");

        // R1 / R2: threshold decode and invalid mode field
        set_cfg(4'b0110, 2, "R1");
        set_cfg(4'b0010, 3, "R2");
        drv(0, 0, 1, 1, 1, 0, 0, "R2");
        drv(0, 1, 1, 1, 0, 0, 1, "R2");
        drv(1, 0, 1, 1, 1, 0, 0, "R2");
        set_cfg(4'b1101, 3, "R2");
        set_cfg(4'b0000, 3, "R2");

        repeat (3) @(posedge clk);
        #2;
        finish_up();
    end

endmodule